// File: doc/BRIEF.md
# SECDED Link Packet Codec

This block protects a 64-bit serial link packet with a single-error-correcting, double-error-detecting code. On the transmit side it takes an 8-bit header and a 48-bit data field (four 12-bit converter samples) and returns a packet made of the header, the data and an 8-bit check byte. On the receive side it takes such a packet, recomputes the check bits, repairs any single flipped bit and flags packets that carry two errors.

The check byte holds six Hamming bits, one overall parity bit and one pad bit that is always zero. Internally the 56 header and data bits are placed on the non-power-of-two positions of a shortened 63-position Hamming codeword. The Hamming bits, which would normally sit on the power-of-two positions, are gathered at the tail of the packet instead. Both paths are valid/ready streams with one register stage each. A path accepts a word when its ready output is high, which happens when its output register is empty or is being drained in the same cycle. While an output is valid and its consumer holds ready low, the output word stays frozen and no new word is taken.

Top module: `secded_link_codec`

## Requirements
- R1: The transmit packet carries the header in bits 63:56, the data in bits 55:8 and a zero in bit 7.
- R2: Counting from packet bit 63 (j = 0) down to bit 8 (j = 55), message bit j occupies the j-th integer of 3, 5, 6, 7, 9, … 62, which are the non-powers of two starting at 3. Transmit bit k of 5:0 is the XOR of the message bits whose position has bit k set.
- R3: Transmit bit 6 is set so that the XOR over all packet bits except bit 7 is zero.
- R4: A received packet that is error-free returns its header and data unchanged, with both status flags low.
- R5: A single flipped bit anywhere in packet bits 63:8 is repaired in the returned header and data, and the corrected flag is raised.
- R6: A single flipped bit in packet bits 5:0 returns the header and data unchanged and raises the corrected flag. A single flip of bit 6 alone returns them unchanged with both flags low.
- R7: Any two flipped bits among packet bits 63:0 other than bit 7 raise the uncorrectable flag, lower the corrected flag and return the received header and data without modification.
- R8: An error pattern whose syndrome is 63, which matches no codeword position, while the overall parity mismatches (for example three flips at positions 3, 5 and 57) raises the uncorrectable flag and returns the received bits unmodified.
- R9: The value of received bit 7 has no effect on the returned fields or flags.
- R10: Each path has a latency of one cycle. Ready is high when the output register is empty or the consumer is ready. A stalled output holds its value. After reset both outputs are invalid and both inputs ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enc_in_valid | input | 1 | Transmit word offered |
| enc_in_ready | output | 1 | Transmit path can take a word |
| enc_in_hdr | input | 8 | Header to protect |
| enc_in_data | input | 48 | Four samples to protect |
| enc_out_valid | output | 1 | Packet available |
| enc_out_ready | input | 1 | Consumer takes the packet |
| enc_out_pkt | output | 64 | Protected packet |
| dec_in_valid | input | 1 | Received packet offered |
| dec_in_ready | output | 1 | Receive path can take a packet |
| dec_in_pkt | input | 64 | Received packet |
| dec_out_valid | output | 1 | Checked result available |
| dec_out_ready | input | 1 | Consumer takes the result |
| dec_out_hdr | output | 8 | Header after correction |
| dec_out_data | output | 48 | Data after correction |
| dec_out_corrected | output | 1 | A single error was found |
| dec_out_uncorrectable | output | 1 | An error that cannot be repaired was found |

## Verification
A wrong entry in the position table or the parity masks corrupts one of the six tail bits for every message that touches that position. It also makes the receive side repair the wrong bit. Both faults show on the very packet that follows, one cycle after acceptance. A stuck or misplaced valid flag in either output register shows as a missing, repeated or changed word in the first cycle of a stall. The sweep over every single-bit flip and every pair of flips reaches each syndrome value, so a bad compare in the correction or classification logic shows within the first few hundred vectors.

// File: rtl/secded_pkg.sv
package secded_pkg;

  // Number of Hamming check bits needed so that the non-power-of-two
  // positions of a (2^p - 1)-position codeword hold msg_w bits.
  function automatic int hamming_bits(input int msg_w);
    int p;
    p = 2;
    while (((1 << p) - p - 1) < msg_w) p++;
    return p;
  endfunction

  // Codeword position of message bit j: the j-th non-power-of-two
  // integer counted from 3 upward.
  function automatic int cw_pos(input int j);
    int cnt;
    int res;
    cnt = 0;
    res = 0;
    for (int p = 3; p < 4 * j + 8; p++) begin
      if ((p & (p - 1)) != 0) begin
        if (cnt == j) res = p;
        cnt++;
      end
    end
    return res;
  endfunction

endpackage

// File: rtl/lnk_pipe_reg.sv
module lnk_pipe_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);

  logic         v_q;
  logic [W-1:0] d_q;

  assign in_ready  = !v_q || out_ready;
  assign out_valid = v_q;
  assign out_data  = d_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        v_q <= 1'b0;
    else if (in_ready) v_q <= in_valid;
  end

  always_ff @(posedge clk) begin
    if (in_ready && in_valid) d_q <= in_data;
  end

  a_r10_stall_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  a_r10_accept_shows: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);

endmodule

// File: rtl/secded_enc.sv
module secded_enc #(
  parameter int MSG_W = 56,
  parameter int PAR_W = 6,
  parameter int ECC_W = 8,
  localparam int PKT_W = MSG_W + ECC_W,
  localparam int PAD_W = ECC_W - PAR_W - 1
) (
  input  logic [MSG_W-1:0] msg,
  output logic [PKT_W-1:0] pkt
);

  logic [PAR_W-1:0] pos_tab [MSG_W];
  logic [PAR_W-1:0] par;
  logic             ovr;

  for (genvar g = 0; g < MSG_W; g++) begin : g_pos
    assign pos_tab[g] = PAR_W'(secded_pkg::cw_pos(g));
  end

  always_comb begin
    par = '0;
    for (int j = 0; j < MSG_W; j++) begin
      if (msg[MSG_W-1-j]) par = par ^ pos_tab[j];
    end
    ovr = (^msg) ^ (^par);
    pkt = {msg, {PAD_W{1'b0}}, ovr, par};
  end

endmodule

// File: rtl/secded_dec.sv
module secded_dec #(
  parameter int MSG_W = 56,
  parameter int PAR_W = 6,
  parameter int ECC_W = 8,
  localparam int PKT_W = MSG_W + ECC_W,
  localparam int PAD_W = ECC_W - PAR_W - 1,
  localparam int MAX_POS = secded_pkg::cw_pos(MSG_W - 1)
) (
  input  logic [PKT_W-1:0] pkt,
  output logic [MSG_W-1:0] msg,
  output logic             corrected,
  output logic             uncorrectable
);

  localparam logic [PKT_W-1:0] KEEP =
    {{MSG_W{1'b1}}, {PAD_W{1'b0}}, {(PAR_W+1){1'b1}}};

  logic [PAR_W-1:0] pos_tab [MSG_W];
  logic [PAR_W-1:0] calc;
  logic [PAR_W-1:0] syn;
  logic             ov_mis;
  logic             in_range;
  logic             single;

  for (genvar g = 0; g < MSG_W; g++) begin : g_pos
    assign pos_tab[g] = PAR_W'(secded_pkg::cw_pos(g));
  end

  always_comb begin
    calc = '0;
    for (int j = 0; j < MSG_W; j++) begin
      if (pkt[PKT_W-1-j]) calc = calc ^ pos_tab[j];
    end
    syn      = calc ^ pkt[PAR_W-1:0];
    ov_mis   = ^(pkt & KEEP);
    in_range = int'(syn) <= MAX_POS;
    single   = ov_mis && (syn != '0) && in_range;

    msg = pkt[PKT_W-1 -: MSG_W];
    if (single) begin
      for (int j = 0; j < MSG_W; j++) begin
        if (syn == pos_tab[j]) msg[MSG_W-1-j] = ~msg[MSG_W-1-j];
      end
    end
    corrected     = single;
    uncorrectable = (syn != '0) && (!ov_mis || !in_range);
  end

endmodule

// File: rtl/secded_link_codec.sv
module secded_link_codec #(
  parameter int HDR_W = 8,
  parameter int SMP_W = 12,
  parameter int N_SMP = 4,
  localparam int DAT_W = SMP_W * N_SMP,
  localparam int MSG_W = HDR_W + DAT_W,
  localparam int PAR_W = secded_pkg::hamming_bits(MSG_W),
  localparam int ECC_W = PAR_W + 2,
  localparam int PKT_W = MSG_W + ECC_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enc_in_valid,
  output logic             enc_in_ready,
  input  logic [HDR_W-1:0] enc_in_hdr,
  input  logic [DAT_W-1:0] enc_in_data,
  output logic             enc_out_valid,
  input  logic             enc_out_ready,
  output logic [PKT_W-1:0] enc_out_pkt,
  input  logic             dec_in_valid,
  output logic             dec_in_ready,
  input  logic [PKT_W-1:0] dec_in_pkt,
  output logic             dec_out_valid,
  input  logic             dec_out_ready,
  output logic [HDR_W-1:0] dec_out_hdr,
  output logic [DAT_W-1:0] dec_out_data,
  output logic             dec_out_corrected,
  output logic             dec_out_uncorrectable
);

  localparam int PAD_W = ECC_W - PAR_W - 1;
  localparam logic [PKT_W-1:0] KEEP =
    {{MSG_W{1'b1}}, {PAD_W{1'b0}}, {(PAR_W+1){1'b1}}};

  // transmit path
  logic [PKT_W-1:0] enc_pkt_c;

  secded_enc #(.MSG_W(MSG_W), .PAR_W(PAR_W), .ECC_W(ECC_W)) enc_i (
    .msg ({enc_in_hdr, enc_in_data}),
    .pkt (enc_pkt_c)
  );

  lnk_pipe_reg #(.W(PKT_W)) enc_stage_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (enc_in_valid),
    .in_ready  (enc_in_ready),
    .in_data   (enc_pkt_c),
    .out_valid (enc_out_valid),
    .out_ready (enc_out_ready),
    .out_data  (enc_out_pkt)
  );

  // receive path
  logic [MSG_W-1:0] dec_msg_c;
  logic             dec_corr_c;
  logic             dec_unc_c;
  logic [MSG_W+1:0] dec_q;

  secded_dec #(.MSG_W(MSG_W), .PAR_W(PAR_W), .ECC_W(ECC_W)) dec_i (
    .pkt           (dec_in_pkt),
    .msg           (dec_msg_c),
    .corrected     (dec_corr_c),
    .uncorrectable (dec_unc_c)
  );

  lnk_pipe_reg #(.W(MSG_W + 2)) dec_stage_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (dec_in_valid),
    .in_ready  (dec_in_ready),
    .in_data   ({dec_msg_c, dec_corr_c, dec_unc_c}),
    .out_valid (dec_out_valid),
    .out_ready (dec_out_ready),
    .out_data  (dec_q)
  );

  assign dec_out_hdr           = dec_q[MSG_W+1 -: HDR_W];
  assign dec_out_data          = dec_q[DAT_W+1:2];
  assign dec_out_corrected     = dec_q[1];
  assign dec_out_uncorrectable = dec_q[0];

  a_r1_pad_zero: assert property (@(posedge clk) disable iff (!rst_n)
    enc_out_valid |-> (enc_out_pkt[ECC_W-1:PAR_W+1] == '0));

  a_r3_even_parity: assert property (@(posedge clk) disable iff (!rst_n)
    enc_out_valid |-> !(^(enc_out_pkt & KEEP)));

  a_r7_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    dec_out_valid |-> !(dec_out_corrected && dec_out_uncorrectable));

  a_r1_header_carried: assert property (@(posedge clk) disable iff (!rst_n)
    (enc_in_valid && enc_in_ready) |=> (enc_out_pkt[PKT_W-1 -: HDR_W] == $past(enc_in_hdr)));

endmodule

// File: tb/secded_link_codec_tb_top.sv
module secded_link_codec_tb_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        enc_in_valid, enc_in_ready;
  logic [7:0]  enc_in_hdr;
  logic [47:0] enc_in_data;
  logic        enc_out_valid, enc_out_ready;
  logic [63:0] enc_out_pkt;
  logic        dec_in_valid, dec_in_ready;
  logic [63:0] dec_in_pkt;
  logic        dec_out_valid, dec_out_ready;
  logic [7:0]  dec_out_hdr;
  logic [47:0] dec_out_data;
  logic        dec_out_corrected, dec_out_uncorrectable;

  int vecs = 0;
  int errs = 0;
  bit done = 0;

  always #10 clk = ~clk;

  secded_link_codec dut_i (
    .clk(clk), .rst_n(rst_n),
    .enc_in_valid(enc_in_valid), .enc_in_ready(enc_in_ready),
    .enc_in_hdr(enc_in_hdr), .enc_in_data(enc_in_data),
    .enc_out_valid(enc_out_valid), .enc_out_ready(enc_out_ready),
    .enc_out_pkt(enc_out_pkt),
    .dec_in_valid(dec_in_valid), .dec_in_ready(dec_in_ready),
    .dec_in_pkt(dec_in_pkt),
    .dec_out_valid(dec_out_valid), .dec_out_ready(dec_out_ready),
    .dec_out_hdr(dec_out_hdr), .dec_out_data(dec_out_data),
    .dec_out_corrected(dec_out_corrected),
    .dec_out_uncorrectable(dec_out_uncorrectable)
  );

  // codeword position of packet bit b (0 for the overall parity bit)
  function automatic int ref_pos(input int b);
    int p, cnt;
    if (b >= 8) begin
      p = 2;
      cnt = -1;
      while (cnt < 63 - b) begin
        p++;
        if ((p & (p - 1)) != 0) cnt++;
      end
      return p;
    end else if (b < 6) begin
      return 1 << b;
    end
    return 0;
  endfunction

  function automatic logic [63:0] ref_enc(input logic [55:0] m);
    logic [63:0] k;
    int s;
    k = {m, 8'h00};
    s = 0;
    for (int b = 8; b < 64; b++) if (k[b]) s = s ^ ref_pos(b);
    k[5:0] = s[5:0];
    k[6] = ^k;
    return k;
  endfunction

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    vecs++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic run_enc(input logic [55:0] m);
    @(negedge clk);
    enc_in_valid = 1'b1;
    enc_in_hdr   = m[55:48];
    enc_in_data  = m[47:0];
    @(negedge clk);
    enc_in_valid = 1'b0;
    check("R10 enc valid", {63'd0, enc_out_valid}, 64'd1);
    check("R1 R2 R3 packet", enc_out_pkt, ref_enc(m));
  endtask

  task automatic run_dec(input string tag, input logic [63:0] p,
                         input logic [55:0] em, input logic ec, input logic eu);
    @(negedge clk);
    dec_in_valid = 1'b1;
    dec_in_pkt   = p;
    @(negedge clk);
    dec_in_valid = 1'b0;
    check({tag, " valid"}, {63'd0, dec_out_valid}, 64'd1);
    check({tag, " fields"}, {8'd0, dec_out_hdr, dec_out_data}, {8'd0, em});
    check({tag, " flags"}, {62'd0, dec_out_corrected, dec_out_uncorrectable},
          {62'd0, ec, eu});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errs++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  end

  initial begin
    logic [55:0] msgs [6];
    logic [55:0] x;
    logic [63:0] good, bad;
    int b57;

    rst_n = 1'b0;
    enc_in_valid = 0; enc_in_hdr = 0; enc_in_data = 0; enc_out_ready = 1;
    dec_in_valid = 0; dec_in_pkt = 0; dec_out_ready = 1;
    repeat (3) @(negedge clk);
    check("R10 reset enc_out_valid", {63'd0, enc_out_valid}, 64'd0);
    check("R10 reset dec_out_valid", {63'd0, dec_out_valid}, 64'd0);
    check("R10 reset ready", {62'd0, enc_in_ready, dec_in_ready}, 64'd3);
    rst_n = 1'b1;

    msgs[0] = '0;
    msgs[1] = '1;
    msgs[2] = {14{4'hA}};
    msgs[3] = {14{4'h5}};
    x = 56'h3C_9E37_79B9_7F4A;
    for (int i = 4; i < 6; i++) begin
      x = x ^ (x << 13);
      x = x ^ (x >> 7);
      x = x ^ (x << 17);
      msgs[i] = x;
    end

    for (int i = 0; i < 6; i++) begin
      good = ref_enc(msgs[i]);
      run_enc(msgs[i]);
      check("R3 even parity", {63'd0, ^(good & ~64'h80)}, 64'd0);
      run_dec("R4 clean", good, msgs[i], 1'b0, 1'b0);
      for (int b = 0; b < 64; b++) begin
        bad = good ^ (64'd1 << b);
        if (b >= 8)      run_dec("R5 single data", bad, msgs[i], 1'b1, 1'b0);
        else if (b < 6)  run_dec("R6 single check", bad, msgs[i], 1'b1, 1'b0);
        else if (b == 6) run_dec("R6 overall only", bad, msgs[i], 1'b0, 1'b0);
        else             run_dec("R9 pad ignored", bad, msgs[i], 1'b0, 1'b0);
      end
      bad = good ^ 64'h80 ^ (64'd1 << (20 + i));
      run_dec("R9 pad with single", bad, msgs[i], 1'b1, 1'b0);
    end

    good = ref_enc(msgs[4]);
    for (int a = 0; a < 64; a++) begin
      for (int c = a + 1; c < 64; c++) begin
        if (a != 7 && c != 7) begin
          bad = good ^ (64'd1 << a) ^ (64'd1 << c);
          run_dec("R7 double", bad, bad[63:8], 1'b0, 1'b1);
        end
      end
    end

    b57 = 0;
    for (int b = 8; b < 64; b++) if (ref_pos(b) == 57) b57 = b;
    bad = good ^ (64'd1 << 63) ^ (64'd1 << 62) ^ (64'd1 << b57);
    run_dec("R8 syndrome out of range", bad, bad[63:8], 1'b0, 1'b1);

    // back-pressure on the transmit path
    @(negedge clk);
    enc_out_ready = 1'b0;
    enc_in_valid  = 1'b1;
    {enc_in_hdr, enc_in_data} = msgs[4];
    @(negedge clk);
    check("R10 stall valid", {63'd0, enc_out_valid}, 64'd1);
    check("R10 stall ready low", {63'd0, enc_in_ready}, 64'd0);
    check("R10 stall first word", enc_out_pkt, ref_enc(msgs[4]));
    {enc_in_hdr, enc_in_data} = msgs[5];
    repeat (2) begin
      @(negedge clk);
      check("R10 stall hold", enc_out_pkt, ref_enc(msgs[4]));
      check("R10 stall ready held low", {63'd0, enc_in_ready}, 64'd0);
    end
    enc_out_ready = 1'b1;
    @(negedge clk);
    enc_in_valid = 1'b0;
    check("R10 second word", enc_out_pkt, ref_enc(msgs[5]));
    check("R10 second valid", {63'd0, enc_out_valid}, 64'd1);
    @(negedge clk);
    check("R10 drained", {63'd0, enc_out_valid}, 64'd0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

endmodule